// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

The block holds a bank of hardware semaphores that several processors use to serialise access to shared resources. Each semaphore is one word on a register port. A master claims a semaphore by writing its own 4-bit master ID there. It then reads the word back and owns the semaphore only if the returned owner field matches its ID. Writing zero releases the semaphore. There is no atomic read-modify-write: arbitration happens inside the bank on the write. A master learns the result from the next read.

The block has several single-cycle register ports, one per bus master. Each access carries the requester's master ID. Reads return data combinationally, from the state held before any write in the same cycle. Writes take effect at the clock edge. A control word selects the signalling protocol. Only the polled protocol, selected by bit 0 at zero, has any effect. A clear-all register accepts write-one-to-clear writes. No interrupt is ever raised, so that register holds no state.

Top module: `hw_sem_bank`

## Requirements
- R1: The bank holds NSEM (default 32) independent semaphores; semaphore i is at byte offset 0x08 + 4*i, and an access to one never changes another.
- R2: A write to a free semaphore whose data equals the writer's master ID (zero-extended, ID nonzero) makes that ID the owner from the next cycle on.
- R3: While a semaphore is held, any nonzero write to it is ignored, whichever master writes it, and the owner field stays unchanged.
- R4: A write of 0x0000_0000 releases a held semaphore (owner field back to 0) only when the writer's master ID equals the current owner; a zero write from any other master is ignored.
- R5: A semaphore read returns the owner ID in bits [3:0] (0 when free) and zeros in bits [31:4]; reads change no state.
- R6: When several ports claim the same free semaphore in one cycle, the lowest master ID wins, independent of port number.
- R7: Master ID 0 is never granted, and a write whose data is neither 0 nor the writer's own ID leaves a free semaphore free.
- R8: The control word at offset 0x00 stores the low CTRL_W bits of a write and reads them back with upper bits zero; bit 0 at 0 means polled protocol.
- R9: Offset 0x90 is the clear-all register: writes such as 0xFFFF are accepted without touching any semaphore or control state, and it reads 0. Unaligned or unmapped offsets read 0, and writes to them have no effect.
- R10: After reset every semaphore is free and the control word is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NP | Per-port access request |
| we_i | input | NP | Per-port write enable (0 = read) |
| addr_i | input | NP x AW | Per-port byte offset |
| wdata_i | input | NP x 32 | Per-port write data |
| mid_i | input | NP x 4 | Per-port requesting master ID |
| rdata_o | output | NP x 32 | Per-port combinational read data |

## Verification
Claims are tried on free and held semaphores, from the owner and from other masters. This separates the free-only grant from the owner-only release. Two ports claim the same semaphore in one cycle, once with the low ID on port 0 and once on port 1. That distinguishes ID priority from port priority. Further cases cover the reserved ID 0, data that does not match the writer's ID, the first and last semaphores, and the control, clear-all and unmapped offsets. These show that decoding confines each write to its own target.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 4;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_SEM,
    TGT_ICR
  } tgt_e;
endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
  import hsem_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned NSEM     = 32,
  parameter int unsigned SEM_BASE = 8,
  parameter int unsigned ICR_OFF  = 144,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [AW-1:0]    addr_i,
  output tgt_e             tgt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [AW-1:0] off;
  logic [AW-1:0] slot;

  always_comb begin
    off   = addr_i - AW'(SEM_BASE);
    slot  = off >> 2;
    idx_o = slot[IDX_W-1:0];
    tgt_o = TGT_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i == '0)
        tgt_o = TGT_CTRL;
      else if (addr_i == AW'(ICR_OFF))
        tgt_o = TGT_ICR;
      else if (addr_i >= AW'(SEM_BASE) && 32'(slot) < NSEM)
        tgt_o = TGT_SEM;
    end
  end
endmodule

// File: rtl/hsem_cell.sv
module hsem_cell
  import hsem_pkg::*;
#(
  parameter int unsigned NP = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0]          wr_hit_i,
  input  logic [NP-1:0]          claim_ok_i,
  input  logic [NP-1:0]          zero_ok_i,
  input  logic [NP-1:0][ID_W-1:0] mid_i,
  output logic [ID_W-1:0]        owner_o
);
  logic [ID_W-1:0] owner_q, owner_d, best;
  logic            rel;

  // lowest requesting ID wins a free semaphore
  always_comb begin
    best = '0;
    rel  = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (wr_hit_i[p] && claim_ok_i[p] && (best == '0 || mid_i[p] < best))
        best = mid_i[p];
      if (wr_hit_i[p] && zero_ok_i[p] && mid_i[p] == owner_q)
        rel = 1'b1;
    end
    if (owner_q == '0)
      owner_d = best;
    else if (rel)
      owner_d = '0;
    else
      owner_d = owner_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= '0;
    else         owner_q <= owner_d;
  end

  assign owner_o = owner_q;

  AST_HELD_ONLY_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q != '0) |=> (owner_q == $past(owner_q) || owner_q == '0)); // R3
  AST_GRANT_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == '0) |=> (owner_q == '0 || $past(|(wr_hit_i & claim_ok_i)))); // R2
  AST_FREE_NEEDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q != '0) |=> (owner_q != '0 || $past(|(wr_hit_i & zero_ok_i)))); // R4
endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank
  import hsem_pkg::*;
#(
  parameter int unsigned NP       = 2,
  parameter int unsigned NSEM     = 32,
  parameter int unsigned AW       = 8,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned SEM_BASE = 8,
  parameter int unsigned ICR_OFF  = 144
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NP-1:0]            req_i,
  input  logic [NP-1:0]            we_i,
  input  logic [NP-1:0][AW-1:0]    addr_i,
  input  logic [NP-1:0][DATA_W-1:0] wdata_i,
  input  logic [NP-1:0][ID_W-1:0]  mid_i,
  output logic [NP-1:0][DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = (NSEM > 1) ? $clog2(NSEM) : 1;

  tgt_e [NP-1:0]                 tgt;
  logic [NP-1:0][IDX_W-1:0]      idx;
  logic [NP-1:0]                 claim_ok, zero_ok, rd_en, wr_en;
  logic [NSEM-1:0][NP-1:0]       sem_wr;
  logic [NSEM-1:0][ID_W-1:0]     owner;
  logic [CTRL_W-1:0]             ctrl_q, ctrl_d;
  logic                          ctrl_we;

  for (genvar p = 0; p < NP; p++) begin : g_port
    hsem_decode #(
      .AW(AW), .NSEM(NSEM), .SEM_BASE(SEM_BASE), .ICR_OFF(ICR_OFF), .IDX_W(IDX_W)
    ) u_dec (
      .addr_i(addr_i[p]),
      .tgt_o (tgt[p]),
      .idx_o (idx[p])
    );
    assign wr_en[p]    = req_i[p] & we_i[p];
    assign rd_en[p]    = req_i[p] & ~we_i[p];
    assign claim_ok[p] = (mid_i[p] != '0) && (wdata_i[p] == DATA_W'(mid_i[p]));
    assign zero_ok[p]  = (wdata_i[p] == '0);

    always_comb begin
      rdata_o[p] = '0;
      if (rd_en[p]) begin
        unique case (tgt[p])
          TGT_CTRL: rdata_o[p] = DATA_W'(ctrl_q);
          TGT_SEM:  rdata_o[p] = DATA_W'(owner[idx[p]]);
          default:  rdata_o[p] = '0;
        endcase
      end
    end

    AST_SEM_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en[p] && tgt[p] == TGT_SEM) |-> (rdata_o[p][DATA_W-1:ID_W] == '0)); // R5
    AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en[p] && (tgt[p] == TGT_NONE || tgt[p] == TGT_ICR)) |-> (rdata_o[p] == '0)); // R9
  end

  always_comb begin
    for (int s = 0; s < NSEM; s++)
      for (int p = 0; p < NP; p++)
        sem_wr[s][p] = wr_en[p] && tgt[p] == TGT_SEM && 32'(idx[p]) == s;
  end

  for (genvar s = 0; s < NSEM; s++) begin : g_sem
    hsem_cell #(.NP(NP)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_hit_i  (sem_wr[s]),
      .claim_ok_i(claim_ok),
      .zero_ok_i (zero_ok),
      .mid_i     (mid_i),
      .owner_o   (owner[s])
    );
  end

  // lowest port index wins a control write collision
  always_comb begin
    ctrl_we = 1'b0;
    ctrl_d  = ctrl_q;
    for (int p = NP - 1; p >= 0; p--) begin
      if (wr_en[p] && tgt[p] == TGT_CTRL) begin
        ctrl_we = 1'b1;
        ctrl_d  = wdata_i[p][CTRL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q)); // R8
endmodule

// File: tb/sim_hw_sem_bank.sv
`timescale 1ns/1ps
module sim_hw_sem_bank;
  localparam int NP = 2;
  localparam int AW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NP-1:0]        req = '0, we = '0;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][31:0]  wdata = '0;
  logic [NP-1:0][3:0]   mid = '0;
  logic [NP-1:0][31:0]  rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hw_sem_bank #(.NP(NP), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .mid_i(mid), .rdata_o(rdata)
  );

  function automatic logic [7:0] sa(int i);
    return 8'(8 + 4 * i);
  endfunction

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic idle();
    req = '0; we = '0;
  endtask

  task automatic wr(int p, logic [7:0] a, logic [31:0] d, logic [3:0] m);
    @(negedge clk);
    idle();
    req[p] = 1'b1; we[p] = 1'b1; addr[p] = a; wdata[p] = d; mid[p] = m;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic wr2(logic [7:0] a, logic [31:0] d0, logic [3:0] m0,
                     logic [31:0] d1, logic [3:0] m1);
    @(negedge clk);
    req = '1; we = '1; addr[0] = a; addr[1] = a;
    wdata[0] = d0; mid[0] = m0; wdata[1] = d1; mid[1] = m1;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic rd_chk(int p, logic [7:0] a, logic [31:0] exp, string r);
    @(negedge clk);
    idle();
    req[p] = 1'b1; we[p] = 1'b0; addr[p] = a; mid[p] = 4'd1;
    #1 chk(r, rdata[p], exp);
    idle();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) rd_chk(i % 2, sa(i), 32'h0, "R10 sem free");
    rd_chk(0, 8'h00, 32'h0, "R10 ctrl zero");
  endtask

  task automatic t_claim();
    wr(0, sa(5), 32'd3, 4'd3);
    rd_chk(1, sa(5), 32'd3, "R2 claim");
    rd_chk(0, sa(5), 32'd3, "R5 read no side effect");
    rd_chk(0, sa(4), 32'd0, "R1 neighbour low");
    rd_chk(0, sa(6), 32'd0, "R1 neighbour high");
  endtask

  task automatic t_held();
    wr(1, sa(5), 32'd7, 4'd7);
    rd_chk(0, sa(5), 32'd3, "R3 foreign claim ignored");
    wr(0, sa(5), 32'd3, 4'd3);
    rd_chk(0, sa(5), 32'd3, "R3 reclaim keeps owner");
    wr(1, sa(5), 32'd0, 4'd7);
    rd_chk(0, sa(5), 32'd3, "R4 foreign release ignored");
    wr(0, sa(5), 32'd0, 4'd3);
    rd_chk(1, sa(5), 32'd0, "R4 owner release");
    wr(1, sa(5), 32'd7, 4'd7);
    rd_chk(0, sa(5), 32'd7, "R2 claim after release");
  endtask

  task automatic t_contend();
    wr2(sa(10), 32'd9, 4'd9, 32'd2, 4'd2);
    rd_chk(0, sa(10), 32'd2, "R6 low id on port1");
    wr2(sa(11), 32'd4, 4'd4, 32'd12, 4'd12);
    rd_chk(1, sa(11), 32'd4, "R6 low id on port0");
  endtask

  task automatic t_id0();
    wr(0, sa(12), 32'd0, 4'd0);
    rd_chk(0, sa(12), 32'd0, "R7 id0 no grant");
    wr(0, sa(12), 32'd6, 4'd5);
    rd_chk(0, sa(12), 32'd0, "R7 mismatched data");
    wr(1, sa(12), 32'h15, 4'd5);
    rd_chk(0, sa(12), 32'd0, "R7 upper bits set");
  endtask

  task automatic t_ctrl();
    wr(0, 8'h00, 32'h1, 4'd1);
    rd_chk(1, 8'h00, 32'h1, "R8 ctrl bit0");
    wr(1, 8'h00, 32'hFFFF_FFFF, 4'd2);
    rd_chk(0, 8'h00, 32'hFF, "R8 ctrl width");
    wr(0, 8'h00, 32'h0, 4'd1);
    rd_chk(0, 8'h00, 32'h0, "R8 polled mode");
  endtask

  task automatic t_icr();
    wr(0, sa(0), 32'd1, 4'd1);
    wr(1, 8'h90, 32'hFFFF, 4'd2);
    rd_chk(0, sa(0), 32'd1, "R9 clear-all keeps sem");
    rd_chk(0, 8'h90, 32'h0, "R9 clear-all reads zero");
    rd_chk(0, 8'h00, 32'h0, "R9 clear-all keeps ctrl");
    wr(0, 8'h04, 32'h5, 4'd5);
    wr(0, sa(0) + 8'd1, 32'h0, 4'd1);
    rd_chk(1, 8'h04, 32'h0, "R9 unmapped read");
    rd_chk(1, 8'h8C, 32'h0, "R9 past last sem");
    rd_chk(1, sa(0) + 8'd1, 32'h0, "R9 unaligned read");
    rd_chk(1, sa(0), 32'd1, "R9 unaligned write ignored");
    rd_chk(1, 8'h00, 32'h0, "R9 unmapped write ignored");
  endtask

  task automatic t_last();
    wr(1, sa(31), 32'd15, 4'd15);
    rd_chk(0, 8'h84, 32'd15, "R1 last semaphore");
    rd_chk(0, sa(30), 32'd0, "R1 below last");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_claim();
    t_held();
    t_contend();
    t_id0();
    t_ctrl();
    t_icr();
    t_last();
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule